// File: doc/BRIEF.md
# EEPROM Status and Write-Guard Controller

This block keeps the status bits of a small serial EEPROM and rules on every write that the device is asked to make. It receives already-decoded one-cycle command strobes from the serial front end: enable writes, disable writes, store new status, set the user mark bit and clear it. It also receives a requested array write with its byte address, the active-low hardware guard pin, and a busy signal from the engine that programs the nonvolatile cells. For each request it answers with a one-cycle permit pulse, either for the array or for the status register. The engine uses that pulse to start a programming cycle.

The status register holds four things. The write-enable latch and the mark bit are volatile and are cleared by reset. A two-bit protected-zone code and a hardware-lock enable bit stand in for nonvolatile cells: they only change through an accepted status write and keep their values across reset. A write cycle opens when a permit is issued and closes on the falling edge of the busy input. Until it closes, every command and request is ignored. When it closes, the write-enable latch drops, so each write needs a fresh enable command.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears the write-enable latch, the mark bit and both permit outputs, and leaves the zone code and the hardware-lock enable bit unchanged.
- R2: When idle, the enable command sets the write-enable latch and the disable command clears it. If both arrive in the same cycle, the latch ends at 0.
- R3: When idle, the mark-set command sets the mark bit and the mark-clear command clears it. If both arrive in the same cycle, the mark ends at 0.
- R4: An array write request is granted only when the block is idle, the write-enable latch is 1 and the address lies outside the protected zone. A grant is a one-cycle pulse on `arr_go` in the cycle after the request. A refused request changes no status bit.
- R5: The protected zone, with the address width ADDR_W set to 12 (a 4096-byte array), is decoded from the two zone bits as follows. Code 00 protects nothing. Code 01 protects the top quarter, which is every address whose two most significant bits are 11 (0xC00 to 0xFFF). Code 10 protects the top half, which is every address whose most significant bit is 1 (0x800 to 0xFFF). Code 11 protects every address.
- R6: A granted status write pulses `sr_go` for one cycle in the cycle after the command. In that same cycle the zone and hardware-lock bits take the values presented with the command. The write-enable latch stays 1 until the cycle closes.
- R7: While the hardware-lock enable bit is 0, the guard pin has no effect: a status write with the write-enable latch at 1 is granted with the pin high or low.
- R8: If the guard pin falls while a granted status write cycle is running, that cycle still completes with the new values. Status writes that come after it are refused while the pin stays low.
- R9: A status write that sets the hardware-lock enable bit to 1 while the pin is low is granted. From the next request on, status writes are refused, and a refused status write leaves the zone and hardware-lock bits unchanged. Status writes are granted again only once the pin is high.
- R10: From a grant until the busy input falls, all commands and requests are ignored: no permit is issued and neither the latch nor the mark changes. When busy falls, the write-enable latch is cleared.
- R11: If a status write and an array write request arrive in the same cycle, only the status write can be granted, and the array request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wen_set | input | 1 | Strobe: set the write-enable latch |
| cmd_wen_clr | input | 1 | Strobe: clear the write-enable latch |
| cmd_stat_wr | input | 1 | Strobe: write the zone and hardware-lock bits |
| cmd_mark_set | input | 1 | Strobe: set the mark bit |
| cmd_mark_clr | input | 1 | Strobe: clear the mark bit |
| stat_zone_d | input | 2 | Zone code presented with a status write |
| stat_hwen_d | input | 1 | Hardware-lock enable presented with a status write |
| guard_n | input | 1 | Hardware guard pin, active low |
| arr_req | input | 1 | Array write request |
| arr_addr | input | ADDR_W | Target byte address of the array write |
| nv_busy | input | 1 | Nonvolatile programming cycle in progress |
| wen_o | output | 1 | Write-enable latch |
| mark_o | output | 1 | Volatile mark bit |
| zone_o | output | 2 | Stored protected-zone code |
| hwen_o | output | 1 | Stored hardware-lock enable bit |
| arr_go | output | 1 | One-cycle permit for an array write |
| sr_go | output | 1 | One-cycle permit for a status write |

## Verification
The two decisions that can meet in one cycle are a status write and an array write, since both draw on the same write-enable latch and open the same single write cycle. The bench presents both strobes on the same clock edge with the latch set and an address outside the zone. It then expects a status permit, no array permit and the new zone code one cycle later. A second collision, the guard pin falling in the middle of a running status cycle, is judged by reading the committed bits and then attempting a follow-up write that must be refused.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [1:0] {
    ZN_NONE    = 2'b00,
    ZN_QUARTER = 2'b01,
    ZN_HALF    = 2'b10,
    ZN_ALL     = 2'b11
  } zone_t;
endpackage

// File: rtl/eewp_zone_chk.sv
module eewp_zone_chk
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  zone_t             zone,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    case (zone)
      ZN_QUARTER: hit = addr[TOP] & addr[TOP-1];
      ZN_HALF:    hit = addr[TOP];
      ZN_ALL:     hit = 1'b1;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/eewp_vol_bits.sv
module eewp_vol_bits (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic wen_set,
  input  logic wen_clr,
  input  logic mark_set,
  input  logic mark_clr,
  input  logic cyc_start,
  input  logic nv_busy,
  output logic wen_q,
  output logic mark_q,
  output logic in_cycle
);
  logic busy_d;
  logic cyc_done;

  assign cyc_done = in_cycle & busy_d & ~nv_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_d   <= 1'b0;
      in_cycle <= 1'b0;
      wen_q    <= 1'b0;
      mark_q   <= 1'b0;
    end else begin
      busy_d <= nv_busy;
      if (cyc_start)     in_cycle <= 1'b1;
      else if (cyc_done) in_cycle <= 1'b0;
      if (cyc_done)                wen_q <= 1'b0;
      else if (idle && wen_clr)    wen_q <= 1'b0;
      else if (idle && wen_set)    wen_q <= 1'b1;
      if (idle && mark_clr)        mark_q <= 1'b0;
      else if (idle && mark_set)   mark_q <= 1'b1;
    end
  end

  // R10: the mark is frozen while programming is busy
  p_mark_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    nv_busy |=> $stable(mark_q));

  // R10: closing a write cycle leaves the latch cleared
  p_wen_drop_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(in_cycle) |-> !wen_q);
endmodule

// File: rtl/eewp_nv_store.sv
module eewp_nv_store
  import eewp_pkg::*;
(
  input  logic  clk,
  input  logic  wr_en,
  input  zone_t zone_d,
  input  logic  hwen_d,
  output zone_t zone_q,
  output logic  hwen_q
);
  // Stand-in for nonvolatile cells: no reset term, load only on a granted write
  always_ff @(posedge clk) begin
    if (wr_en) begin
      zone_q <= zone_d;
      hwen_q <= hwen_d;
    end
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wen_set,
  input  logic              cmd_wen_clr,
  input  logic              cmd_stat_wr,
  input  logic              cmd_mark_set,
  input  logic              cmd_mark_clr,
  input  logic [1:0]        stat_zone_d,
  input  logic              stat_hwen_d,
  input  logic              guard_n,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              nv_busy,
  output logic              wen_o,
  output logic              mark_o,
  output logic [1:0]        zone_o,
  output logic              hwen_o,
  output logic              arr_go,
  output logic              sr_go
);
  logic  in_cycle, wen_q, mark_q, hwen_q, addr_hit;
  logic  idle, stat_ok, arr_ok, stat_locked;
  zone_t zone_q;

  assign idle        = ~nv_busy & ~in_cycle;
  assign stat_locked = hwen_q & ~guard_n;
  assign stat_ok     = cmd_stat_wr & idle & wen_q & ~stat_locked;
  assign arr_ok      = arr_req & idle & wen_q & ~addr_hit & ~cmd_stat_wr;

  eewp_zone_chk #(.ADDR_W(ADDR_W)) u_zone (
    .zone (zone_q),
    .addr (arr_addr),
    .hit  (addr_hit)
  );

  eewp_vol_bits u_vol (
    .clk       (clk),
    .rst       (rst),
    .idle      (idle),
    .wen_set   (cmd_wen_set),
    .wen_clr   (cmd_wen_clr),
    .mark_set  (cmd_mark_set),
    .mark_clr  (cmd_mark_clr),
    .cyc_start (stat_ok | arr_ok),
    .nv_busy   (nv_busy),
    .wen_q     (wen_q),
    .mark_q    (mark_q),
    .in_cycle  (in_cycle)
  );

  eewp_nv_store u_nv (
    .clk    (clk),
    .wr_en  (stat_ok),
    .zone_d (zone_t'(stat_zone_d)),
    .hwen_d (stat_hwen_d),
    .zone_q (zone_q),
    .hwen_q (hwen_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_go <= 1'b0;
      sr_go  <= 1'b0;
    end else begin
      arr_go <= arr_ok;
      sr_go  <= stat_ok;
    end
  end

  assign wen_o  = wen_q;
  assign mark_o = mark_q;
  assign zone_o = zone_q;
  assign hwen_o = hwen_q;

  // R4: an array permit needs the latch set on the request cycle
  p_arr_needs_wen_r4: assert property (@(posedge clk) disable iff (rst)
    arr_go |-> $past(wen_q));

  // R5: no array permit while every address is protected
  p_arr_zone_all_r5: assert property (@(posedge clk) disable iff (rst)
    arr_go |-> ($past(zone_q) != ZN_ALL));

  // R9: no status permit in locked mode
  p_stat_locked_r9: assert property (@(posedge clk) disable iff (rst)
    sr_go |-> !($past(hwen_q) && !$past(guard_n)));

  // R6: stored bits move only together with a status permit
  p_nv_moves_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable({zone_q, hwen_q}) |-> sr_go);

  // R11: never both permits at once
  p_go_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(arr_go && sr_go));
endmodule

// File: tb/eeprom_wp_ctrl_bench.sv
module eeprom_wp_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wen_set = 0, cmd_wen_clr = 0, cmd_stat_wr = 0;
  logic cmd_mark_set = 0, cmd_mark_clr = 0;
  logic [1:0] stat_zone_d = 0;
  logic stat_hwen_d = 0, guard_n = 1, arr_req = 0, nv_busy = 0;
  logic [AW-1:0] arr_addr = 0;
  logic wen_o, mark_o, hwen_o, arr_go, sr_go;
  logic [1:0] zone_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [1:0] m_zone;
  logic m_hwen;

  always #(CLK_PER/2) clk = ~clk;

  eeprom_wp_ctrl #(.ADDR_W(AW)) u_eeprom_wp_ctrl (
    .clk(clk), .rst(rst), .cmd_wen_set(cmd_wen_set), .cmd_wen_clr(cmd_wen_clr),
    .cmd_stat_wr(cmd_stat_wr), .cmd_mark_set(cmd_mark_set), .cmd_mark_clr(cmd_mark_clr),
    .stat_zone_d(stat_zone_d), .stat_hwen_d(stat_hwen_d), .guard_n(guard_n),
    .arr_req(arr_req), .arr_addr(arr_addr), .nv_busy(nv_busy),
    .wen_o(wen_o), .mark_o(mark_o), .zone_o(zone_o), .hwen_o(hwen_o),
    .arr_go(arr_go), .sr_go(sr_go)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic prot(logic [1:0] z, logic [AW-1:0] a);
    case (z)
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wen_pulse();
    cmd_wen_set = 1; step(); cmd_wen_set = 0;
  endtask

  task automatic wen_drop();
    cmd_wen_clr = 1; step(); cmd_wen_clr = 0;
  endtask

  task automatic run_cycle(string tag);
    nv_busy = 1; repeat (3) step();
    nv_busy = 0; step();
    chk({tag, " latch cleared at close"}, wen_o, 0);
  endtask

  // status write attempt; exp_ok derived from the bench model of R6/R7/R9
  task automatic stat_write(string tag, logic [1:0] z, logic h);
    logic ok;
    ok = !(m_hwen && !guard_n);
    wen_pulse();
    cmd_stat_wr = 1; stat_zone_d = z; stat_hwen_d = h;
    step();
    cmd_stat_wr = 0;
    chk({tag, " sr_go"}, sr_go, ok);
    if (ok) begin m_zone = z; m_hwen = h; end
    chk({tag, " zone"}, zone_o, m_zone);
    chk({tag, " hwen"}, hwen_o, m_hwen);
    if (ok) begin
      chk({tag, " latch held in cycle"}, wen_o, 1);
      run_cycle(tag);
    end else wen_drop();
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) step(); rst = 0; step();
    chk("R1 latch after reset", wen_o, 0);
    chk("R1 mark after reset", mark_o, 0);
    chk("R1 permits after reset", {arr_go, sr_go}, 0);
  endtask

  task automatic t_latch();
    wen_pulse();               chk("R2 set", wen_o, 1);
    wen_drop();                chk("R2 clear", wen_o, 0);
    cmd_wen_set = 1; cmd_wen_clr = 1; step();
    cmd_wen_set = 0; cmd_wen_clr = 0;
    chk("R2 both strobes", wen_o, 0);
  endtask

  task automatic t_mark();
    cmd_mark_set = 1; step(); cmd_mark_set = 0; chk("R3 set", mark_o, 1);
    cmd_mark_clr = 1; step(); cmd_mark_clr = 0; chk("R3 clear", mark_o, 0);
    cmd_mark_set = 1; cmd_mark_clr = 1; step();
    cmd_mark_set = 0; cmd_mark_clr = 0;
    chk("R3 both strobes", mark_o, 0);
  endtask

  task automatic t_zones();
    logic [AW-1:0] probes [6] = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
    guard_n = 1;
    // request without the latch
    arr_req = 1; arr_addr = 12'h100; step(); arr_req = 0;
    chk("R4 no latch refused", arr_go, 0);
    for (int z = 0; z < 4; z++) begin
      stat_write("R5 zone load", 2'(z), 1'b0);
      for (int p = 0; p < 6; p++) begin
        wen_pulse();
        arr_req = 1; arr_addr = probes[p]; step(); arr_req = 0;
        chk("R5 zone decode", arr_go, !prot(2'(z), probes[p]));
        if (arr_go) run_cycle("R4");
        else begin
          chk("R4 refused keeps latch", wen_o, 1);
          wen_drop();
        end
      end
    end
  endtask

  task automatic t_pin_ignored();
    stat_write("R7 clear hwen", 2'b00, 1'b0);
    guard_n = 0;
    stat_write("R7 pin low", 2'b01, 1'b0);
    chk("R7 accepted zone", zone_o, 2'b01);
    guard_n = 1;
  endtask

  task automatic t_enter_locked();
    guard_n = 0;
    stat_write("R9 enter", 2'b10, 1'b1);
    chk("R9 hwen stored", hwen_o, 1);
    stat_write("R9 refused", 2'b00, 1'b0);
    chk("R9 zone kept", zone_o, 2'b10);
    guard_n = 1;
    stat_write("R9 pin high", 2'b00, 1'b0);
    chk("R9 unlocked", hwen_o, 0);
  endtask

  task automatic t_pin_mid_cycle();
    guard_n = 1;
    stat_write("R8 arm", 2'b01, 1'b1);
    wen_pulse();
    cmd_stat_wr = 1; stat_zone_d = 2'b10; stat_hwen_d = 1; step(); cmd_stat_wr = 0;
    chk("R8 granted", sr_go, 1);
    m_zone = 2'b10; m_hwen = 1;
    guard_n = 0;
    nv_busy = 1; repeat (3) step(); nv_busy = 0; step();
    chk("R8 cycle completed zone", zone_o, 2'b10);
    chk("R8 latch cleared", wen_o, 0);
    stat_write("R8 later refused", 2'b00, 1'b0);
    chk("R8 zone kept", zone_o, 2'b10);
    guard_n = 1;
    stat_write("R8 restore", 2'b00, 1'b0);
  endtask

  task automatic t_quiet_cycle();
    wen_pulse();
    arr_req = 1; arr_addr = 12'h010; step(); arr_req = 0;
    chk("R10 grant", arr_go, 1);
    cmd_mark_set = 1; cmd_stat_wr = 1; stat_zone_d = 2'b11; step();
    cmd_mark_set = 0; cmd_stat_wr = 0;
    chk("R10 mark ignored", mark_o, 0);
    chk("R10 stat ignored", sr_go, 0);
    chk("R10 zone kept", zone_o, m_zone);
    nv_busy = 1; step();
    cmd_wen_clr = 1; arr_req = 1; step(); cmd_wen_clr = 0; arr_req = 0;
    chk("R10 disable ignored", wen_o, 1);
    chk("R10 array ignored", arr_go, 0);
    step(); nv_busy = 0; step();
    chk("R10 latch cleared at close", wen_o, 0);
  endtask

  task automatic t_collide();
    wen_pulse();
    arr_req = 1; arr_addr = 12'h020; cmd_stat_wr = 1; stat_zone_d = 2'b01; stat_hwen_d = 0;
    step();
    arr_req = 0; cmd_stat_wr = 0;
    chk("R11 status granted", sr_go, 1);
    chk("R11 array refused", arr_go, 0);
    m_zone = 2'b01; m_hwen = 0;
    chk("R11 zone", zone_o, 2'b01);
    run_cycle("R11");
  endtask

  task automatic t_retain();
    stat_write("R1 load", 2'b10, 1'b0);
    cmd_mark_set = 1; step(); cmd_mark_set = 0;
    wen_pulse();
    rst = 1; step(); step(); rst = 0; step();
    chk("R1 zone kept", zone_o, 2'b10);
    chk("R1 hwen kept", hwen_o, 0);
    chk("R1 latch cleared", wen_o, 0);
    chk("R1 mark cleared", mark_o, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    m_zone = 2'b00; m_hwen = 1'b0;
    stat_write("R6 initial load", 2'b00, 1'b0);
    t_latch();
    t_mark();
    t_zones();
    t_pin_ignored();
    t_enter_locked();
    t_pin_mid_cycle();
    t_quiet_cycle();
    t_collide();
    t_retain();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule